// File: doc/BRIEF.md
# Watchdog Timer with Halt Freeze and Wake Delay

This block is the reset watchdog of a small 8-bit controller. Software writes an 8-bit control word that holds an activation flag in its top bit and a 7-bit down-counter below it. A prescaler divides the core clock, and each prescaled tick lowers the counter by one. When the counter's top bit falls from 1 to 0, the block raises a one-cycle reset request for the chip's reset logic. Software keeps the chip alive by rewriting the counter with its top bit set before that moment. Writing the top bit clear makes the block reset the chip on purpose.

A configuration input picks one of two enable modes. In software mode the watchdog starts disabled. Once software sets the activation flag, the flag stays set until the next reset. In hardware mode the watchdog counts from reset onward, and the activation flag in writes has no effect.

The block also follows the halt low-power state. A halt-permit bit and a USB-suspend input decide what happens on halt. The watchdog either freezes or issues a reset. After an external wake-up it holds counting off for a fixed number of core clocks. The counting output shows when the watchdog is running.

Top module: `wdt_halt_guard`

## Requirements
- R1: After reset in software mode, cr_rdata reads 0x7F, counting is 0 and wdt_rst_req is 0. After reset in hardware mode, cr_rdata reads 0xFF and counting is 1.
- R2: In the control word, bit 7 is the activation flag and bits 6..0 are the counter, with bit 6 as its top bit. A write loads the counter and restarts the prescaler. A write made while the watchdog is frozen or waiting after a wake-up is ignored.
- R3: While counting, the counter drops by one every PRESC_DIV clocks. The first drop is seen PRESC_DIV cycles after the clock edge that takes the write.
- R4: When the counter drops from 0x40 to 0x3F, wdt_rst_req is 1 for exactly one cycle, the cycle right after that drop.
- R5: A write with bit 6 clear raises wdt_rst_req in the cycle after the write, if the watchdog is enabled or the written bit 7 is 1.
- R6: In software mode the activation flag, read as cr_rdata bit 7, is cleared only by reset. A write with bit 7 = 0 leaves it set.
- R7: In software mode with the flag clear, the counter does not count. A write with bits 7 and 6 both clear gives no reset request. A halt entry is ignored.
- R8: In hardware mode the watchdog always counts and cr_rdata bit 7 reads 1. Bit 7 of a write has no effect.
- R9: If halt_enter comes while the watchdog is enabled and halt_permit = 1, counting stops and the counter holds its value. No reset request is issued until ext_wake arrives.
- R10: After ext_wake is taken in the frozen state, counting stays 0 for exactly WAKE_CLKS clocks (514 by default) and then returns to 1.
- R11: If halt_enter comes while the watchdog is enabled, with halt_permit = 0 and usb_suspend = 0, wdt_rst_req is 1 in the next cycle and counting continues.
- R12: While usb_suspend = 1, a halt entry never raises a reset request. It freezes the watchdog in the same way as R9, even when halt_permit = 0.
- R13: counting is 1 exactly when the watchdog is enabled and neither frozen nor waiting after a wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| hw_mode | input | 1 | 1 selects hardware enable mode, 0 selects software mode |
| cr_we | input | 1 | Control word write strobe |
| cr_wdata | input | 8 | Control word write data: flag in bit 7, counter in bits 6..0 |
| halt_permit | input | 1 | Halt-permit bit from the miscellaneous register |
| halt_enter | input | 1 | One-cycle pulse when the core enters halt |
| ext_wake | input | 1 | One-cycle pulse for an external wake-up interrupt |
| usb_suspend | input | 1 | USB suspend state is active |
| cr_rdata | output | 8 | Control word read-back: enable in bit 7, counter in bits 6..0 |
| counting | output | 1 | The watchdog is counting |
| wdt_rst_req | output | 1 | One-cycle chip reset request |

## Verification
Every result is registered once, so a write, a halt entry or a final counter drop shows on wdt_rst_req and cr_rdata in the cycle right after the clock edge that takes it. Counter drops come PRESC_DIV edges after a write. Counting comes back WAKE_CLKS edges after the wake edge. The bench drives inputs on falling edges and counts falling edges from the edge that took each stimulus. It samples one cycle before and one cycle after each due point, so an early or late change is caught. Across long frozen stretches, it counts reset pulses on rising edges to show that none occurred.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W   = 7;
    localparam int CR_W    = CNT_W + 1;
    localparam int TOP_BIT = CNT_W - 1;
    localparam int ACT_BIT = CNT_W;

    typedef enum logic [1:0] {
        WD_LIVE     = 2'd0,
        WD_FROZEN   = 2'd1,
        WD_RESUMING = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    assign tick = run && (pre_q.cnt == LAST);

    always_comb begin
        pre_d = pre_q;
        if (clr) begin
            pre_d.cnt = '0;
        end else if (run) begin
            pre_d.cnt = tick ? '0 : pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/wdt_wake_timer.sv
module wdt_wake_timer
    import wdt_pkg::*;
#(
    parameter int WAKE_CLKS = 514
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      freeze,
    input  logic      wake,
    output wd_state_e state
);
    localparam int DW = (WAKE_CLKS > 1) ? $clog2(WAKE_CLKS) : 1;
    localparam logic [DW-1:0] RELOAD = DW'(WAKE_CLKS - 1);

    typedef struct packed {
        wd_state_e     st;
        logic [DW-1:0] dly;
    } wk_t;

    wk_t wk_d, wk_q;

    assign state = wk_q.st;

    always_comb begin
        wk_d = wk_q;
        unique case (wk_q.st)
            WD_LIVE: begin
                if (freeze) begin
                    wk_d.st = WD_FROZEN;
                end
            end
            WD_FROZEN: begin
                if (wake) begin
                    wk_d.st  = WD_RESUMING;
                    wk_d.dly = RELOAD;
                end
            end
            WD_RESUMING: begin
                if (wk_q.dly == '0) begin
                    wk_d.st = WD_LIVE;
                end else begin
                    wk_d.dly = wk_q.dly - 1'b1;
                end
            end
            default: begin
                wk_d.st = WD_LIVE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q.st  <= WD_LIVE;
            wk_q.dly <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_mode,
    input  logic             cr_we,
    input  logic [CR_W-1:0]  cr_wdata,
    input  logic             tick,
    input  logic             live,
    input  logic             halt_enter,
    input  logic             halt_permit,
    input  logic             usb_suspend,
    output logic             wr_take,
    output logic             freeze,
    output logic             enabled,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] EXPIRE_AT = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_INIT  = '1;

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic             rst_req;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic halt_take;
    logic en_after;

    assign enabled   = hw_mode | ctl_q.act;
    assign wr_take   = cr_we & live;
    assign halt_take = halt_enter & live & enabled;
    assign freeze    = halt_take & (halt_permit | usb_suspend);
    assign en_after  = enabled | cr_wdata[ACT_BIT];
    assign cnt       = ctl_q.cnt;
    assign rst_req   = ctl_q.rst_req;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rst_req = 1'b0;
        if (wr_take) begin
            ctl_d.cnt = cr_wdata[CNT_W-1:0];
            if (!hw_mode && cr_wdata[ACT_BIT]) begin
                ctl_d.act = 1'b1;
            end
            if (en_after && !cr_wdata[TOP_BIT]) begin
                ctl_d.rst_req = 1'b1;
            end
        end else if (tick && enabled && live) begin
            ctl_d.cnt = ctl_q.cnt - 1'b1;
            if (ctl_q.cnt == EXPIRE_AT) begin
                ctl_d.rst_req = 1'b1;
            end
        end
        if (halt_take && !halt_permit && !usb_suspend) begin
            ctl_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.act     <= 1'b0;
            ctl_q.cnt     <= CNT_INIT;
            ctl_q.rst_req <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/wdt_halt_guard.sv
module wdt_halt_guard
    import wdt_pkg::*;
#(
    parameter int PRESC_DIV = 16,
    parameter int WAKE_CLKS = 514
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_mode,
    input  logic            cr_we,
    input  logic [CR_W-1:0] cr_wdata,
    input  logic            halt_permit,
    input  logic            halt_enter,
    input  logic            ext_wake,
    input  logic            usb_suspend,
    output logic [CR_W-1:0] cr_rdata,
    output logic            counting,
    output logic            wdt_rst_req
);
    wd_state_e        frz_state;
    logic             live;
    logic             tick;
    logic             wr_take;
    logic             freeze;
    logic             enabled;
    logic [CNT_W-1:0] cnt;

    assign live     = (frz_state == WD_LIVE);
    assign counting = enabled & live;
    assign cr_rdata = {enabled, cnt};

    wdt_prescaler #(.DIV(PRESC_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (counting),
        .clr   (wr_take),
        .tick  (tick)
    );

    wdt_wake_timer #(.WAKE_CLKS(WAKE_CLKS)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze),
        .wake   (ext_wake),
        .state  (frz_state)
    );

    wdt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_mode     (hw_mode),
        .cr_we       (cr_we),
        .cr_wdata    (cr_wdata),
        .tick        (tick),
        .live        (live),
        .halt_enter  (halt_enter),
        .halt_permit (halt_permit),
        .usb_suspend (usb_suspend),
        .wr_take     (wr_take),
        .freeze      (freeze),
        .enabled     (enabled),
        .cnt         (cnt),
        .rst_req     (wdt_rst_req)
    );
endmodule

// File: rtl/wdt_halt_guard_chk.sv
module wdt_halt_guard_chk
    import wdt_pkg::*;
#(
    parameter int WAKE_CLKS = 514
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cr_we,
    input logic            halt_enter,
    input logic            halt_permit,
    input logic            usb_suspend,
    input logic [CR_W-1:0] cr_rdata,
    input logic            wdt_rst_req,
    input logic            live,
    input logic            tick,
    input wd_state_e       frz_state
);
    localparam int KW = $clog2(WAKE_CLKS + 2) + 1;
    logic [KW-1:0] wk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= (frz_state == WD_RESUMING) ? wk_q + 1'b1 : '0;
        end
    end

    // R9
    frozen_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && !$past(live)) |-> !wdt_rst_req);

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(live) |-> $stable(cr_rdata));

    // R6
    sticky_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cr_rdata[ACT_BIT]) |-> cr_rdata[ACT_BIT]);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cr_rdata[ACT_BIT]) && !$past(cr_we)) |-> $stable(cr_rdata[CNT_W-1:0]));

    // R10
    wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> (wk_q == KW'(WAKE_CLKS)));

    // R11
    halt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt_enter && live && cr_rdata[ACT_BIT] && !halt_permit && !usb_suspend)
        |-> wdt_rst_req);

    // R4
    expiry_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && live && !cr_we && cr_rdata[CNT_W-1:0] == {1'b1, {(CNT_W-1){1'b0}}})
        |-> wdt_rst_req);
endmodule

bind wdt_halt_guard wdt_halt_guard_chk #(.WAKE_CLKS(WAKE_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_we       (cr_we),
    .halt_enter  (halt_enter),
    .halt_permit (halt_permit),
    .usb_suspend (usb_suspend),
    .cr_rdata    (cr_rdata),
    .wdt_rst_req (wdt_rst_req),
    .live        (live),
    .tick        (tick),
    .frz_state   (frz_state)
);

// File: tb/wdt_halt_guard_test.sv
`timescale 1ns/1ps
module wdt_halt_guard_test;
    localparam int DIV = 16;
    localparam int WK  = 514;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_mode = 1'b0;
    logic       cr_we = 1'b0;
    logic [7:0] cr_wdata = '0;
    logic       halt_permit = 1'b0;
    logic       halt_enter = 1'b0;
    logic       ext_wake = 1'b0;
    logic       usb_suspend = 1'b0;
    logic [7:0] cr_rdata;
    logic       counting;
    logic       wdt_rst_req;

    int total = 0;
    int bad = 0;
    int npulse = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (wdt_rst_req === 1'b1) npulse <= npulse + 1;

    wdt_halt_guard #(.PRESC_DIV(DIV), .WAKE_CLKS(WK)) uut (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cr_we(cr_we),
        .cr_wdata(cr_wdata), .halt_permit(halt_permit), .halt_enter(halt_enter),
        .ext_wake(ext_wake), .usb_suspend(usb_suspend), .cr_rdata(cr_rdata),
        .counting(counting), .wdt_rst_req(wdt_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic hw);
        rst_n = 1'b0; hw_mode = hw; cr_we = 1'b0;
        halt_enter = 1'b0; ext_wake = 1'b0; halt_permit = 1'b0; usb_suspend = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        cr_we = 1'b1; cr_wdata = d;
        @(negedge clk);
        cr_we = 1'b0;
    endtask

    task automatic halt_pulse();
        halt_enter = 1'b1;
        @(negedge clk);
        halt_enter = 1'b0;
    endtask

    task automatic wake_pulse();
        ext_wake = 1'b1;
        @(negedge clk);
        ext_wake = 1'b0;
    endtask

    task automatic t_reset_and_idle();
        int p0;
        do_reset(1'b0);
        check("R1 rdata after reset", cr_rdata, 8'h7F);
        check("R1 counting after reset", counting, 0);
        check("R1 rst_req after reset", wdt_rst_req, 0);
        wr(8'h05);
        check("R7 no reset on disabled write", wdt_rst_req, 0);
        check("R2 counter loaded", cr_rdata, 8'h05);
        p0 = npulse;
        step(3 * DIV);
        check("R7 no counting when disabled", cr_rdata, 8'h05);
        halt_pulse();
        check("R7 halt ignored counting", counting, 0);
        step(2);
        check("R7 halt gives no reset", npulse - p0, 0);
        wr(8'hC5);
        check("R7 halt ignored, enable live", counting, 1);
    endtask

    task automatic t_expiry();
        do_reset(1'b0);
        wr(8'hC1);
        check("R13 counting once enabled", counting, 1);
        check("R3 value at write", cr_rdata, 8'hC1);
        step(DIV - 1);
        check("R3 no early drop", cr_rdata, 8'hC1);
        step(1);
        check("R3 drop on time", cr_rdata, 8'hC0);
        check("R4 no reset above threshold", wdt_rst_req, 0);
        step(DIV - 1);
        check("R4 no early reset", wdt_rst_req, 0);
        step(1);
        check("R4 counter after final drop", cr_rdata, 8'hBF);
        check("R4 reset on top-bit fall", wdt_rst_req, 1);
        step(1);
        check("R4 reset one cycle", wdt_rst_req, 0);
    endtask

    task automatic t_sticky();
        do_reset(1'b0);
        wr(8'hFF);
        wr(8'h7F);
        check("R6 flag stays set", cr_rdata, 8'hFF);
        check("R6 still counting", counting, 1);
        check("R6 no reset on refresh", wdt_rst_req, 0);
        do_reset(1'b0);
        check("R6 reset clears flag", cr_rdata[7], 0);
    endtask

    task automatic t_forced();
        do_reset(1'b0);
        wr(8'hA0);
        check("R5 forced reset with flag write", wdt_rst_req, 1);
        step(1);
        check("R5 forced pulse ends", wdt_rst_req, 0);
        wr(8'hD0);
        wr(8'h10);
        check("R5 forced reset while enabled", wdt_rst_req, 1);
    endtask

    task automatic t_hw();
        do_reset(1'b1);
        check("R1 hw rdata after reset", cr_rdata, 8'hFF);
        check("R8 hw counting after reset", counting, 1);
        wr(8'h50);
        check("R8 flag reads one", cr_rdata, 8'hD0);
        check("R8 no reset on refresh", wdt_rst_req, 0);
        step(DIV);
        check("R8 hw counts", cr_rdata, 8'hCF);
        wr(8'h30);
        check("R5 hw forced reset", wdt_rst_req, 1);
    endtask

    task automatic t_halt_permit();
        logic [7:0] held;
        int p0;
        do_reset(1'b0);
        wr(8'hE0);
        step(3);
        halt_permit = 1'b1;
        halt_pulse();
        check("R9 counting stops", counting, 0);
        check("R9 no reset at halt", wdt_rst_req, 0);
        held = cr_rdata;
        p0 = npulse;
        step(2000);
        check("R9 counter held", cr_rdata, held);
        wr(8'h85);
        check("R2 write ignored while frozen", cr_rdata, held);
        halt_permit = 1'b0;
        halt_pulse();
        step(2);
        check("R9 no reset while frozen", npulse - p0, 0);
        wake_pulse();
        check("R10 still off after wake", counting, 0);
        step(WK - 1);
        check("R10 off one clock before delay", counting, 0);
        step(1);
        check("R10 on after delay", counting, 1);
        step(3 * DIV);
        check("R9 counting resumes", (cr_rdata != held), 1);
        halt_pulse();
        check("R11 reset without permit", wdt_rst_req, 1);
        check("R11 counting continues", counting, 1);
        step(1);
        check("R11 pulse ends", wdt_rst_req, 0);
    endtask

    task automatic t_usb();
        logic [7:0] held;
        int p0;
        do_reset(1'b0);
        wr(8'hF0);
        usb_suspend = 1'b1;
        halt_permit = 1'b0;
        p0 = npulse;
        halt_pulse();
        check("R12 no reset under suspend", wdt_rst_req, 0);
        check("R12 frozen under suspend", counting, 0);
        held = cr_rdata;
        step(100);
        check("R12 counter held", cr_rdata, held);
        check("R12 no pulses", npulse - p0, 0);
        wake_pulse();
        step(WK);
        check("R12 resumes after delay", counting, 1);
        usb_suspend = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset_and_idle();
        t_expiry();
        t_sticky();
        t_forced();
        t_hw();
        t_halt_permit();
        t_usb();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL run timeout: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule